// File: doc/BRIEF.md
# DDR3 Power-Up Reset and Clock-Enable Sequencer

This block takes an external DDR3 device through its power-up pin sequence. On a start request it drives the memory reset pin low and holds it there for a programmed number of counter ticks. It then releases the reset pin and keeps the clock-enable pin low for a second programmed number of ticks. After that it raises clock-enable and reports ready, so that the mode-register initialisation logic that follows can begin.

The tick counter advances once every two or once every three memory clocks, depending on a silicon-variant select. The same programmed value therefore lasts longer on the three-clock variant. Both programmed counts are raised to a floor computed from the clock frequency parameter. This keeps the reset-low time at 200 µs or more and the post-reset clock-enable wait at 500 µs or more, whatever value the delay word holds. The reset value of the delay word is 0x00C80064, which asks for 200 reset ticks and 100 clock-enable ticks.

Top module: `dram_pwrup_seq`

## Requirements
- R1: After synchronous reset the block is idle: `mem_reset_n`=0, `mem_cke`=0, `busy`=0 and `ready`=0.
- R2: A `start` pulse seen while idle or ready makes `busy`=1 and `mem_reset_n`=0 on the next cycle.
- R3: `mem_reset_n` stays low for exactly Tr×D cycles from the first busy cycle. Tr is the clamped reset tick count.
- R4: Once `mem_reset_n` goes high, `mem_cke` stays low for exactly Tc×D cycles, where Tc is the clamped clock-enable tick count. On the cycle `mem_cke` rises, `ready` becomes 1 and `busy` becomes 0.
- R5: D, the clocks per tick, is 2 when `tick_div3`=0 and 3 when `tick_div3`=1.
- R6: The reset tick floor is ceil(ceil(MIN_RST_NS×CLK_MHZ/1000)/D). The clock-enable tick floor is ceil(ceil(MIN_CKE_NS×CLK_MHZ/1000)/D). A programmed count below its floor, including 0, is replaced by the floor.
- R7: `init_dly[31:16]` holds the reset-low tick count and `init_dly[15:0]` holds the clock-enable wait tick count.
- R8: While busy, `start` is ignored. Changes on `init_dly` and `tick_div3` after a start has been accepted do not alter the sequence in progress.
- R9: `mem_cke` is never high while `mem_reset_n` is low. `ready` and `mem_cke` stay high until a new start or a reset.
- R10: A `start` while ready begins a complete new sequence, with `mem_cke` and `ready` dropping on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the power-up sequence |
| init_dly | input | 32 | Delay word: reset ticks [31:16], clock-enable ticks [15:0] |
| tick_div3 | input | 1 | Variant select: 0 gives 2 clocks per tick, 1 gives 3 |
| mem_reset_n | output | 1 | DDR3 reset pin, active low |
| mem_cke | output | 1 | DDR3 clock-enable pin |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Sequence complete; initialisation may proceed |

## Verification
The hardest cases to reach are the ones that stress the latched configuration. These are a start pulse in the middle of a running sequence, and a change to the delay word or the variant select after the start has already been accepted. The bench reaches them by pulsing start partway through both waiting phases of some runs. In the same runs it drives the bitwise inverse of the delay word and the opposite variant, then checks that both measured phase lengths still match the values that were in place at acceptance. Directed runs with zero fields and fields exactly at the floor exercise the clamp on both variants.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RST_LOW  = 2'd1,
        ST_CKE_WAIT = 2'd2,
        ST_READY    = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [15:0] rst_ticks;
        logic [15:0] cke_ticks;
    } delay_word_t;

    localparam logic [31:0] DELAY_WORD_RESET = 32'h00C8_0064;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/dps_tick_gen.sv
module dps_tick_gen #(
    parameter int unsigned DIV_FAST = 2,
    parameter int unsigned DIV_SLOW = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic slow,
    output logic tick
);
    localparam int unsigned W = (DIV_SLOW > DIV_FAST) ? $clog2(DIV_SLOW) : $clog2(DIV_FAST);
    localparam logic [W-1:0] TERM_FAST = W'(DIV_FAST - 1);
    localparam logic [W-1:0] TERM_SLOW = W'(DIV_SLOW - 1);

    logic [W-1:0] phase_q;
    logic [W-1:0] term;

    assign term = slow ? TERM_SLOW : TERM_FAST;
    assign tick = en && (phase_q == term);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/dps_floor_clamp.sv
module dps_floor_clamp #(
    parameter int unsigned CNT_W    = 20,
    parameter int unsigned MIN_FAST = 1,
    parameter int unsigned MIN_SLOW = 1
) (
    input  logic [15:0]      field,
    input  logic             slow,
    output logic [CNT_W-1:0] eff
);
    localparam logic [CNT_W-1:0] FLOOR_FAST = CNT_W'(MIN_FAST);
    localparam logic [CNT_W-1:0] FLOOR_SLOW = CNT_W'(MIN_SLOW);

    logic [CNT_W-1:0] wide;
    logic [CNT_W-1:0] floor_v;

    always_comb begin
        wide    = CNT_W'(field);
        floor_v = slow ? FLOOR_SLOW : FLOOR_FAST;
        eff     = (wide < floor_v) ? floor_v : wide;
    end
endmodule

// File: rtl/dps_span_counter.sv
module dps_span_counter #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             last
);
    logic [CNT_W-1:0] remain_q;

    assign last = (remain_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (tick && !last) begin
            remain_q <= remain_q - 1'b1;
        end
    end
endmodule

// File: rtl/dram_pwrup_seq.sv
module dram_pwrup_seq
    import dps_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 400,
    parameter int unsigned MIN_RST_NS = 200000,
    parameter int unsigned MIN_CKE_NS = 500000,
    parameter int unsigned DIV_FAST   = 2,
    parameter int unsigned DIV_SLOW   = 3,
    parameter int unsigned CNT_W      = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] init_dly,
    input  logic        tick_div3,
    output logic        mem_reset_n,
    output logic        mem_cke,
    output logic        busy,
    output logic        ready
);
    localparam int unsigned RST_MIN_CYC  = ceil_div(MIN_RST_NS * CLK_MHZ, 1000);
    localparam int unsigned CKE_MIN_CYC  = ceil_div(MIN_CKE_NS * CLK_MHZ, 1000);
    localparam int unsigned RST_MIN_FAST = at_least_one(ceil_div(RST_MIN_CYC, DIV_FAST));
    localparam int unsigned RST_MIN_SLOW = at_least_one(ceil_div(RST_MIN_CYC, DIV_SLOW));
    localparam int unsigned CKE_MIN_FAST = at_least_one(ceil_div(CKE_MIN_CYC, DIV_FAST));
    localparam int unsigned CKE_MIN_SLOW = at_least_one(ceil_div(CKE_MIN_CYC, DIV_SLOW));

    seq_state_t       state_q, state_d;
    delay_word_t      dly_w;
    logic             slow_q;
    logic [CNT_W-1:0] rst_eff, cke_eff, cke_eff_q;
    logic             accept, counting, tick, last, phase_end, load;
    logic [CNT_W-1:0] load_val;

    assign dly_w = delay_word_t'(init_dly);

    dps_floor_clamp #(
        .CNT_W(CNT_W), .MIN_FAST(RST_MIN_FAST), .MIN_SLOW(RST_MIN_SLOW)
    ) u_rst_clamp (
        .field(dly_w.rst_ticks), .slow(tick_div3), .eff(rst_eff)
    );

    dps_floor_clamp #(
        .CNT_W(CNT_W), .MIN_FAST(CKE_MIN_FAST), .MIN_SLOW(CKE_MIN_SLOW)
    ) u_cke_clamp (
        .field(dly_w.cke_ticks), .slow(tick_div3), .eff(cke_eff)
    );

    assign counting  = (state_q == ST_RST_LOW) || (state_q == ST_CKE_WAIT);
    assign accept    = start && ((state_q == ST_IDLE) || (state_q == ST_READY));
    assign phase_end = counting && tick && last;
    assign load      = accept || (phase_end && (state_q == ST_RST_LOW));
    assign load_val  = accept ? rst_eff : cke_eff_q;

    dps_tick_gen #(
        .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)
    ) u_tick (
        .clk(clk), .rst(rst), .clr(load), .en(counting), .slow(slow_q), .tick(tick)
    );

    dps_span_counter #(
        .CNT_W(CNT_W)
    ) u_span (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .tick(tick), .last(last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_READY: if (accept)    state_d = ST_RST_LOW;
            ST_RST_LOW:        if (phase_end) state_d = ST_CKE_WAIT;
            ST_CKE_WAIT:       if (phase_end) state_d = ST_READY;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            slow_q    <= 1'b0;
            cke_eff_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                slow_q    <= tick_div3;
                cke_eff_q <= cke_eff;
            end
        end
    end

    assign mem_reset_n = (state_q == ST_CKE_WAIT) || (state_q == ST_READY);
    assign mem_cke     = (state_q == ST_READY);
    assign ready       = (state_q == ST_READY);
    assign busy        = counting;
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
    parameter int unsigned RST_MIN_CYC = 1,
    parameter int unsigned CKE_MIN_CYC = 1
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic mem_reset_n,
    input logic mem_cke,
    input logic busy,
    input logic ready
);
    int unsigned low_cnt;
    int unsigned wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= 0;
            wait_cnt <= 0;
        end else begin
            low_cnt  <= (!mem_reset_n && busy) ? low_cnt + 1 : 0;
            wait_cnt <= (mem_reset_n && !mem_cke && busy) ? wait_cnt + 1 : 0;
        end
    end

    AST_CKE_NEEDS_RESET_HIGH: assert property (@(posedge clk) disable iff (rst)
        mem_cke |-> mem_reset_n); // R9
    AST_READY_WITH_CKE: assert property (@(posedge clk) disable iff (rst)
        ready |-> mem_cke); // R4
    AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && ready)); // R4
    AST_RESET_LOW_FLOOR: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_reset_n) |-> low_cnt >= RST_MIN_CYC); // R6
    AST_CKE_WAIT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cke) |-> wait_cnt >= CKE_MIN_CYC); // R6
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ready); // R9
    AST_RESTART_FROM_READY: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> (busy && !mem_reset_n && !mem_cke)); // R10
endmodule

bind dram_pwrup_seq dps_checker #(
    .RST_MIN_CYC(RST_MIN_CYC),
    .CKE_MIN_CYC(CKE_MIN_CYC)
) u_dps_checker (
    .clk(clk), .rst(rst), .start(start), .mem_reset_n(mem_reset_n),
    .mem_cke(mem_cke), .busy(busy), .ready(ready)
);

// File: tb/dram_pwrup_seq_bench.sv
module dram_pwrup_seq_bench;
    localparam int unsigned CLK_MHZ    = 1;
    localparam int unsigned MIN_RST_NS = 200000;
    localparam int unsigned MIN_CKE_NS = 500000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] init_dly = 32'h00C8_0064;
    logic        tick_div3 = 1'b0;
    logic        mem_reset_n, mem_cke, busy, ready;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dram_pwrup_seq #(
        .CLK_MHZ(CLK_MHZ), .MIN_RST_NS(MIN_RST_NS), .MIN_CKE_NS(MIN_CKE_NS)
    ) u_dram_pwrup_seq (
        .clk(clk), .rst(rst), .start(start), .init_dly(init_dly), .tick_div3(tick_div3),
        .mem_reset_n(mem_reset_n), .mem_cke(mem_cke), .busy(busy), .ready(ready)
    );

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int clocks_per_tick(input logic v);
        return v ? 3 : 2;
    endfunction

    function automatic int floor_ticks(input int ns, input logic v);
        int cyc = cdiv(ns * CLK_MHZ, 1000);
        return cdiv(cyc, clocks_per_tick(v));
    endfunction

    function automatic int phase_len(input int field, input int ns, input logic v);
        int f = floor_ticks(ns, v);
        return ((field < f) ? f : field) * clocks_per_tick(v);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input logic [31:0] dly, input logic v, input bit disturb,
                           input int k, input string start_tag);
        int exp_low  = phase_len(int'(dly[31:16]), MIN_RST_NS, v);
        int exp_wait = phase_len(int'(dly[15:0]), MIN_CKE_NS, v);
        int n = 1;
        int m = 1;
        bit order_bad = 1'b0;
        @(negedge clk);
        init_dly = dly; tick_div3 = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !mem_reset_n && !mem_cke && !ready, start_tag,
              {busy, mem_reset_n, mem_cke, ready}, 4'b1000);
        for (int i = 0; i < 20000; i++) begin
            if (disturb && i == k) begin
                start = 1'b1; init_dly = ~dly; tick_div3 = ~v;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (mem_cke && !mem_reset_n) order_bad = 1'b1;
            if (mem_reset_n) break;
            n++;
        end
        check(n == exp_low, disturb ? "R3 R5 R7 R8" : "R3 R5 R6 R7", n, exp_low);
        for (int i = 0; i < 20000; i++) begin
            start = (disturb && i == k) ? 1'b1 : 1'b0;
            @(negedge clk);
            if (mem_cke && !mem_reset_n) order_bad = 1'b1;
            if (mem_cke) break;
            m++;
        end
        start = 1'b0;
        check(m == exp_wait, disturb ? "R4 R5 R7 R8" : "R4 R5 R6 R7", m, exp_wait);
        check(ready && !busy && mem_reset_n, "R4", {ready, busy, mem_reset_n}, 3'b101);
        check(!order_bad, "R9", order_bad, 0);
        init_dly = dly;
        repeat (6) @(negedge clk);
        check(ready && mem_cke && !busy, "R9", {ready, mem_cke, busy}, 3'b110);
    endtask

    initial begin
        #1_500_000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd8125));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!mem_reset_n && !mem_cke && !busy && !ready, "R1",
              {mem_reset_n, mem_cke, busy, ready}, 0);
        // R8 start is only sampled on a cycle edge; idle holds without start
        repeat (4) @(negedge clk);
        check(!busy && !ready, "R1", {busy, ready}, 0);

        // Directed: reset default word on both variants
        run_seq(32'h00C8_0064, 1'b0, 1'b0, 0, "R2");
        run_seq(32'h00C8_0064, 1'b1, 1'b0, 0, "R10");
        // Directed: zero fields clamp to the floor (R6)
        run_seq(32'h0000_0000, 1'b0, 1'b0, 0, "R10");
        run_seq(32'h0000_0000, 1'b1, 1'b0, 0, "R10");
        // Directed: fields exactly at the floor, then one above (R6)
        run_seq({16'(floor_ticks(MIN_RST_NS, 1'b1)), 16'(floor_ticks(MIN_CKE_NS, 1'b1))},
                1'b1, 1'b0, 0, "R10");
        run_seq({16'(floor_ticks(MIN_RST_NS, 1'b0) + 1), 16'(floor_ticks(MIN_CKE_NS, 1'b0) + 1)},
                1'b0, 1'b0, 0, "R10");
        // Directed: mid-sequence start and input changes ignored (R8)
        run_seq(32'h012C_0150, 1'b0, 1'b1, 7, "R10");
        run_seq(32'h0005_0003, 1'b1, 1'b1, 20, "R10");

        // Random runs
        for (int r = 0; r < 10; r++) begin
            logic [15:0] fr = 16'($urandom_range(0, 380));
            logic [15:0] fc = 16'($urandom_range(0, 380));
            logic        vv = 1'($urandom_range(0, 1));
            bit          dd = 1'($urandom_range(0, 1));
            int          kk = int'($urandom_range(2, 60));
            run_seq({fr, fc}, vv, dd, kk, "R10");
        end

        // R1 synchronous reset from ready returns to idle
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_reset_n && !mem_cke && !busy && !ready, "R1",
              {mem_reset_n, mem_cke, busy, ready}, 0);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule